// File: doc/BRIEF.md
# Processor Bus Cycle Strobe Generator

This block sits between a 16-bit processor core and its two external buses and turns a plain per-cycle access request into the registered strobe set the outside world sees. The main memory bus has two byte lanes. A separate peripheral extension bus has an active-low select. Each request gives an access kind (instruction fetch, data read, data write, or none), a bus choice, a word/byte size and the address LSB. The block answers with a fetch flag, a memory read/write line, upper and lower byte-lane selects, an extension-bus select and an extension-bus read/write line.

A boot-space flag comes from a one-bit configuration register. Software writes it through bit 3 of a configuration word. All strobes are registered, so they only change at the start of a processor cycle and hold for the whole cycle. When no request is pending, the strobes sit at an idle pattern.

Top module: `bus_strobe_gen`

## Requirements
- R1: Reset is synchronous and active low. At every clock edge where `rst_n` is low, all seven outputs become 1. The boot flag register also becomes 1.
- R2: Every output is a register. Each output reflects the inputs sampled at the previous rising edge and holds steady until the next rising edge.
- R3: A valid request with `req_kind` = 2'b00 is a fetch. It gives `fetch_o`=1, both byte selects = 1, `mem_rw_o`=1, `ext_sel_n_o`=1 and `ext_rw_o`=1. For a fetch, `req_ext`, `req_word` and `req_addr_lsb` have no effect.
- R4: A valid memory read (`req_kind` = 2'b01, `req_ext`=0) gives `mem_rw_o`=1, `fetch_o`=0, `ext_sel_n_o`=1 and `ext_rw_o`=1.
- R5: A valid memory write (`req_kind` = 2'b10, `req_ext`=0) gives `mem_rw_o`=0. `mem_rw_o` is 0 in no other case.
- R6: Byte lanes for memory data accesses work as follows. With `req_word`=1, both `upper_sel_o` and `lower_sel_o` are 1. With a byte access and `req_addr_lsb`=0, only `upper_sel_o` is 1. With a byte access and `req_addr_lsb`=1, only `lower_sel_o` is 1.
- R7: A valid extension access (`req_ext`=1, `req_kind` 2'b01 or 2'b10) gives `ext_sel_n_o`=0, both byte selects = 0 and `mem_rw_o`=1. `ext_rw_o` is 0 only for the write kind 2'b10.
- R8: With `req_valid`=0, or with `req_kind` = 2'b11, the outputs go idle on the next cycle. Idle means `fetch_o`=0, both byte selects = 0, `mem_rw_o`=1, `ext_sel_n_o`=1 and `ext_rw_o`=1.
- R9: When `cfg_wr_en`=1, bit 3 of `cfg_wr_data` is loaded into the boot flag and appears on `boot_o` on the next cycle. Other data bits have no effect. Without a write, `boot_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock; rising edge starts a cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is requested for the next cycle |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| req_ext | input | 1 | 1 selects the extension bus, 0 the memory bus |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_addr_lsb | input | 1 | Address bit 0, picks the byte lane |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_data | input | 16 | Configuration word; bit 3 is the boot flag |
| fetch_o | output | 1 | High during an instruction fetch cycle |
| boot_o | output | 1 | Boot-space flag |
| mem_rw_o | output | 1 | Memory read/write; low only for a memory write |
| upper_sel_o | output | 1 | Memory data bits 15..8 take part |
| lower_sel_o | output | 1 | Memory data bits 7..0 take part |
| ext_sel_n_o | output | 1 | Extension bus select, active low |
| ext_rw_o | output | 1 | Extension read/write; low only for an extension write |

## Verification
Every strobe, including the boot flag after a configuration write and the all-ones pattern after a reset edge, is due exactly one rising edge after the inputs that cause it are sampled. The bench model computes its expectation at that same rising edge from the sampled inputs. The bench changes inputs and compares outputs only at the falling edge, half a cycle away from the edge where the design moves. It compares every cycle, so a strobe that is a cycle early, a cycle late, or that changes in the middle of a cycle produces a mismatch.

// File: rtl/bsg_pkg.sv
// Shared types for the bus strobe generator.
// Assumes a two-bit access kind code and a six-strobe bundle for
// everything except the boot flag, which has its own register.
package bsg_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic fetch;
        logic mem_rw;
        logic upper;
        logic lower;
        logic ext_sel_n;
        logic ext_rw;
    } strobes_t;

    localparam strobes_t STROBES_RESET = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam strobes_t STROBES_IDLE  = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

endpackage

// File: rtl/bsg_lane_decode.sv
// Byte-lane decode for the memory data bus.
// Lane 1 is the upper byte and lane 0 the lower byte. A word access
// enables every lane. A byte access enables the upper lane when the
// address LSB is 0 and the lower lane when it is 1.
// Assumes LANES is 2. The generate loop keeps the lane slice explicit.
module bsg_lane_decode #(
    parameter int LANES = 2
) (
    input  logic             word,
    input  logic             addr_lsb,
    output logic [LANES-1:0] lane_en
);

    localparam int LAST = LANES - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Each lane is on for a word, or for a byte whose address selects it.
        localparam logic PICK_LSB = (g == LAST) ? 1'b0 : 1'b1;
        always_comb begin
            lane_en[g] = word || (addr_lsb == PICK_LSB);
        end
    end

endmodule

// File: rtl/bsg_cycle_decode.sv
// Combinational decode of one access request into the next cycle's strobes.
// A fetch always uses the memory bus as a full word. Data accesses go
// to the memory bus or the extension bus as req_ext selects. Kind
// ACC_NONE and an invalid request both give the idle pattern.
module bsg_cycle_decode
    import bsg_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] kind,
    input  logic       ext,
    input  logic       word,
    input  logic       addr_lsb,
    output strobes_t   next
);

    logic [1:0] lanes;
    acc_kind_e  k;

    bsg_lane_decode #(.LANES(2)) u_lanes (
        .word     (word),
        .addr_lsb (addr_lsb),
        .lane_en  (lanes)
    );

    // Pick the strobe pattern for the access kind and bus.
    always_comb begin
        k    = acc_kind_e'(kind);
        next = STROBES_IDLE;
        if (valid) begin
            unique case (k)
                ACC_FETCH: begin
                    next.fetch = 1'b1;
                    next.upper = 1'b1;
                    next.lower = 1'b1;
                end
                ACC_READ, ACC_WRITE: begin
                    if (ext) begin
                        next.ext_sel_n = 1'b0;
                        next.ext_rw    = (k != ACC_WRITE);
                    end else begin
                        next.mem_rw = (k != ACC_WRITE);
                        next.upper  = lanes[1];
                        next.lower  = lanes[0];
                    end
                end
                default: next = STROBES_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bsg_boot_cfg.sv
// Boot-space flag register.
// Loads the selected bit of a configuration word when a write strobe
// arrives and holds it otherwise. Synchronous active-low reset sets
// the flag to 1.
module bsg_boot_cfg #(
    parameter int CFG_W    = 16,
    parameter int BOOT_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             boot
);

    logic unused_cfg_bits;

    // The other configuration bits have no function in this block.
    always_comb unused_cfg_bits = ^wr_data;

    // Capture the boot bit on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)     boot <= 1'b1;
        else if (wr_en) boot <= wr_data[BOOT_BIT];
    end

    // R9
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (boot == $past(wr_data[BOOT_BIT])));

    // R9
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(boot));

endmodule

// File: rtl/bus_strobe_gen.sv
// Bus cycle strobe generator (top).
// Registers the decoded strobes once per processor cycle, so every
// strobe is stable from one rising edge to the next. Reset is
// synchronous and active low and drives every output to 1.
// Assumes the request inputs are valid at each rising clock edge.
module bus_strobe_gen
    import bsg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int BOOT_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ext,
    input  logic             req_word,
    input  logic             req_addr_lsb,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic             fetch_o,
    output logic             boot_o,
    output logic             mem_rw_o,
    output logic             upper_sel_o,
    output logic             lower_sel_o,
    output logic             ext_sel_n_o,
    output logic             ext_rw_o
);

    strobes_t next_s;
    strobes_t cur_s;

    bsg_cycle_decode u_decode (
        .valid    (req_valid),
        .kind     (req_kind),
        .ext      (req_ext),
        .word     (req_word),
        .addr_lsb (req_addr_lsb),
        .next     (next_s)
    );

    bsg_boot_cfg #(.CFG_W(CFG_W), .BOOT_BIT(BOOT_BIT)) u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .boot    (boot_o)
    );

    // Launch the new strobe set at the start of each processor cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_s <= STROBES_RESET;
        else        cur_s <= next_s;
    end

    // Drive the ports from the strobe register.
    always_comb begin
        fetch_o     = cur_s.fetch;
        mem_rw_o    = cur_s.mem_rw;
        upper_sel_o = cur_s.upper;
        lower_sel_o = cur_s.lower;
        ext_sel_n_o = cur_s.ext_sel_n;
        ext_rw_o    = cur_s.ext_rw;
    end

    // R5
    mem_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rw_o && $past(rst_n)) |->
            $past(req_valid && req_kind == 2'b10 && !req_ext));

    // R3
    fetch_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00) |=> (fetch_o && upper_sel_o && lower_sel_o));

    // R6
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext && !req_word && (req_kind == 2'b01 || req_kind == 2'b10))
            |=> ($countones({upper_sel_o, lower_sel_o}) == 1));

    // R7
    ext_rw_inside_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rw_o |-> !ext_sel_n_o);

    // R8
    idle_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!fetch_o && !upper_sel_o && !lower_sel_o && mem_rw_o && ext_sel_n_o && ext_rw_o));

endmodule

// File: tb/bus_strobe_gen_test.sv
// Bench: a behavioural reference model computes each cycle's expected
// strobes at the rising edge. Comparisons and new stimulus happen at
// the falling edge.
module bus_strobe_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b11;
    logic        req_ext = 1'b0;
    logic        req_word = 1'b0;
    logic        req_addr_lsb = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic fetch_o, boot_o, mem_rw_o, upper_sel_o, lower_sel_o, ext_sel_n_o, ext_rw_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [6:0] exp_v = 7'h7f;
    logic       boot_ref = 1'b1;
    string      exp_tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    bus_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ext(req_ext), .req_word(req_word), .req_addr_lsb(req_addr_lsb),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .fetch_o(fetch_o), .boot_o(boot_o), .mem_rw_o(mem_rw_o),
        .upper_sel_o(upper_sel_o), .lower_sel_o(lower_sel_o),
        .ext_sel_n_o(ext_sel_n_o), .ext_rw_o(ext_rw_o)
    );

    // Reference model, order {fetch, boot, mem_rw, upper, lower, ext_sel_n, ext_rw}.
    always @(posedge clk) begin
        logic f, mrw, u, l, es, erw, b;
        string t;
        b = boot_ref;
        f = 0; mrw = 1; u = 0; l = 0; es = 1; erw = 1; t = "R8";
        if (!rst_n) begin
            b = 1; f = 1; u = 1; l = 1; t = "R1";
        end else begin
            if (cfg_wr_en) b = cfg_wr_data[3];
            if (req_valid && req_kind == 2'b00) begin
                f = 1; u = 1; l = 1; t = "R3";
            end else if (req_valid && (req_kind == 2'b01 || req_kind == 2'b10)) begin
                if (req_ext) begin
                    es = 0; erw = (req_kind == 2'b01); t = "R7";
                end else begin
                    mrw = (req_kind == 2'b01);
                    t = (req_kind == 2'b01) ? "R4" : "R5";
                    if (req_word) begin u = 1; l = 1; end
                    else begin
                        u = (req_addr_lsb == 0); l = (req_addr_lsb == 1);
                        t = {t, "+R6"};
                    end
                end
            end
            if (cfg_wr_en) t = {t, "+R9"};
        end
        boot_ref <= b;
        exp_v    <= {f, b, mrw, u, l, es, erw};
        exp_tag  <= t;
    end

    task automatic step(input logic v, input logic [1:0] k, input logic e,
                        input logic w, input logic a);
        logic [6:0] act;
        @(negedge clk);
        act = {fetch_o, boot_o, mem_rw_o, upper_sel_o, lower_sel_o, ext_sel_n_o, ext_rw_o};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s (R2 one-cycle registered) at %0t: actual=%b expected=%b",
                     exp_tag, $time, act, exp_v);
        end
        req_valid = v; req_kind = k; req_ext = e; req_word = w; req_addr_lsb = a;
        cfg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: outputs held at ones during reset.
        repeat (3) step(1, 2'b10, 0, 1, 0);
        rst_n = 1'b1;
        step(1, 2'b00, 1, 0, 1);   // R3 fetch ignores ext/size/lsb
        step(1, 2'b01, 0, 1, 0);   // R4 word read
        step(1, 2'b10, 0, 1, 0);   // R5 word write
        step(1, 2'b01, 0, 0, 0);   // R6 byte upper
        step(1, 2'b10, 0, 0, 1);   // R6 byte lower
        step(1, 2'b01, 1, 1, 0);   // R7 ext read
        step(1, 2'b10, 1, 0, 1);   // R7 ext write
        step(1, 2'b11, 0, 1, 0);   // R8 kind none
        step(0, 2'b10, 0, 1, 0);   // R8 not valid
        // R9: clear boot with only bit 3 low, other bits set.
        @(negedge clk); cfg_wr_data = 16'hfff7; cfg_wr_en = 1'b1;
        step(1, 2'b00, 0, 1, 0);
        step(0, 2'b00, 0, 1, 0);
        // R9: other bits alone do not set it.
        @(negedge clk); cfg_wr_data = 16'h0000; cfg_wr_en = 1'b1;
        step(1, 2'b10, 1, 1, 0);
        @(negedge clk); cfg_wr_data = 16'h0008; cfg_wr_en = 1'b1;
        step(1, 2'b01, 0, 0, 1);
        step(0, 2'b00, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0) begin
                @(negedge clk); cfg_wr_data = 16'($urandom); cfg_wr_en = 1'b1;
            end
            step(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (i == 200) begin
                rst_n = 1'b0;   // R1 mid-run reset
                step(1, 2'b10, 0, 0, 1);
                step(1, 2'b10, 1, 0, 1);
                rst_n = 1'b1;
            end
        end
        step(0, 2'b11, 0, 0, 0);
        step(0, 2'b11, 0, 0, 0);
        finish_run();
    end

endmodule